// File: doc/BRIEF.md
# Grouped Partial-Product Multiply-Accumulate Unit

This block multiplies two signed 16-bit operands and adds the product into a 40-bit running total, one product per clock when the input strobe is high. The multiplier operand is recoded into radix-4 signed digits, so eight partial-product rows are formed rather than sixteen. The row array is cut by column into four rectangular slices of equal width. Each slice is summed by its own short carry-propagate multi-operand adder. Positions that a row does not reach are zero. The slice sums are packed into two non-overlapping vectors whose sum is the product.

The running total never passes through a long carry chain on the accumulate path. It is held as three 40-bit vectors whose sum, taken modulo 2^40, is the accumulated value. A two-row array of (3,2) counters folds the stored vectors and the new product vectors back into three vectors each cycle. A separate three-input adder converts the state into a plain two's complement result only when the host raises the convert request. That suits filters and dot products, where the binary value is needed only after many terms.

A two-state controller chooses how a product enters the state. In ST_EMPTY, the state after reset or a clear, the first product is loaded directly. In ST_LOADED it is folded through the counters. The transitions are:
- ST_EMPTY to ST_LOADED on an accepted accumulate.
- Either state to ST_EMPTY on clear.
- Otherwise the state is held.

Top module: `gpp_mac`

## Requirements
- R1: The multiplier is recoded into eight radix-4 digits from {-2,-1,0,+1,+2}. Digit k is taken from multiplier bits 2k+1, 2k and 2k-1, with bit -1 read as 0. Row k is the digit times the sign-extended multiplicand, shifted left by 2k. Negative rows carry leading 1s. The rows sum to the signed product, including for operand value 0x8000.
- R2: The row array is split into four column slices of 10 bits each. Each slice is summed over all eight rows into a 13-bit result. Slices 0 and 2 are packed into one vector, and slices 1 and 3 into the other, each at its own column offset. The two vectors sum to the product modulo 2^40.
- R3: In a cycle with in_valid high and clr low, the state total red_s0+red_s1+red_s2 (mod 2^40) grows by the sign-extended product of mcand and mplier.
- R4: clr zeroes all three state vectors at the next edge and takes priority over in_valid in the same cycle.
- R5: With in_valid and clr both low, all three state vectors hold their values, whatever the operand inputs do.
- R6: When cvt_req is high, at the next edge bin_out receives the state total as it stood in the request cycle, and bin_valid is high for that one cycle. An accumulate in the same cycle is not included in the result.
- R7: While cvt_req is low, bin_out holds its value and bin_valid is low in the following cycle.
- R8: After reset, the state vectors, bin_out and bin_valid are all zero.
- R9: The total wraps modulo 2^40. 512 products of 0x8000×0x8000 give 0x8000000000, and 1024 give 0.
- R10: The first accepted accumulate after reset or clear loads the product vectors directly and leaves red_s2 at zero. A later accumulate folds the product through the (3,2) counter array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accumulate the current operand pair this cycle |
| clr | input | 1 | Zero the accumulated state |
| cvt_req | input | 1 | Request conversion of the state to binary |
| mcand | input | 16 | Signed multiplicand |
| mplier | input | 16 | Signed multiplier (recoded) |
| red_s0 | output | 40 | Redundant state vector 0 |
| red_s1 | output | 40 | Redundant state vector 1 |
| red_s2 | output | 40 | Redundant state vector 2 |
| bin_out | output | 40 | Converted two's complement total |
| bin_valid | output | 1 | bin_out updated in this cycle |

## Verification
The assertions check the arithmetic invariants on every cycle:
- The recoded rows always sum to the true product.
- The two packed slice vectors always sum to the rows.
- The three-vector total moves by exactly one product per accepted strobe.
- A clear, an idle cycle and a convert request each have their stated effect one edge later.

Only the bench scenarios can show the rest. These are whole sequences checked against an independent reference sum: extreme operands, back-to-back accumulation, clear and convert colliding with an accumulate, and the 2^40 wrap reached after hundreds of products.

// File: rtl/gpp_mac_pkg.sv
package gpp_mac_pkg;
    localparam int OPERAND_W = 16;
    localparam int TOTAL_W   = 40;
    localparam int SLICES    = 4;

    typedef enum logic {
        ST_EMPTY  = 1'b0,
        ST_LOADED = 1'b1
    } acc_state_e;
endpackage

// File: rtl/gpp_booth_rows.sv
module gpp_booth_rows #(
    parameter int OP_W  = gpp_mac_pkg::OPERAND_W,
    parameter int ACC_W = gpp_mac_pkg::TOTAL_W
) (
    input  logic [OP_W-1:0]                  x_in,
    input  logic [OP_W-1:0]                  y_in,
    output logic [OP_W/2-1:0][ACC_W-1:0]     rows
);
    localparam int PP_N = OP_W / 2;
    localparam int PP_W = OP_W + 2;
    localparam int EXT  = ACC_W - PP_W;

    logic signed [PP_W-1:0] x_ext;
    assign x_ext = {{2{x_in[OP_W-1]}}, x_in};

    for (genvar k = 0; k < PP_N; k++) begin : g_row
        logic [2:0]             trip;
        logic signed [PP_W-1:0] pp;
        if (k == 0) begin : g_first
            assign trip = {y_in[1], y_in[0], 1'b0};
        end else begin : g_rest
            assign trip = {y_in[2*k+1], y_in[2*k], y_in[2*k-1]};
        end
        always_comb begin
            unique case (trip)
                3'b001, 3'b010: pp = x_ext;
                3'b011:         pp = x_ext <<< 1;
                3'b100:         pp = -(x_ext <<< 1);
                3'b101, 3'b110: pp = -x_ext;
                default:        pp = '0;
            endcase
        end
        assign rows[k] = {{EXT{pp[PP_W-1]}}, pp} << (2 * k);
    end

    // R1 checker: row sum against an independent signed multiply
    logic [ACC_W-1:0] row_total;
    logic [ACC_W-1:0] ref_prod;
    always_comb begin
        row_total = '0;
        for (int r = 0; r < PP_N; r++) row_total = row_total + rows[r];
        ref_prod = $signed({{(ACC_W-OP_W){x_in[OP_W-1]}}, x_in})
                 * $signed({{(ACC_W-OP_W){y_in[OP_W-1]}}, y_in});
        if (!$isunknown({x_in, y_in})) begin
            a_r1_booth_sum: assert (row_total == ref_prod)
                else $error("R1 booth rows %h != product %h", row_total, ref_prod);
        end
    end
endmodule

// File: rtl/gpp_slice_adder.sv
module gpp_slice_adder #(
    parameter int ACC_W = gpp_mac_pkg::TOTAL_W,
    parameter int PP_N  = gpp_mac_pkg::OPERAND_W / 2,
    parameter int LO    = 0,
    parameter int SW    = 10,
    parameter int GW    = 13
) (
    input  logic [PP_N-1:0][ACC_W-1:0] rows,
    output logic [GW-1:0]              gsum
);
    always_comb begin
        gsum = '0;
        for (int r = 0; r < PP_N; r++) begin
            gsum = gsum + GW'(rows[r][LO +: SW]);
        end
    end
endmodule

// File: rtl/gpp_group_mult.sv
module gpp_group_mult #(
    parameter int ACC_W  = gpp_mac_pkg::TOTAL_W,
    parameter int PP_N   = gpp_mac_pkg::OPERAND_W / 2,
    parameter int GROUPS = gpp_mac_pkg::SLICES
) (
    input  logic [PP_N-1:0][ACC_W-1:0] rows,
    output logic [ACC_W-1:0]           vec_even,
    output logic [ACC_W-1:0]           vec_odd
);
    localparam int SW = ACC_W / GROUPS;
    localparam int GW = SW + $clog2(PP_N);

    logic [GROUPS-1:0][GW-1:0] gs;

    for (genvar g = 0; g < GROUPS; g++) begin : g_slice
        gpp_slice_adder #(
            .ACC_W(ACC_W), .PP_N(PP_N), .LO(g * SW), .SW(SW), .GW(GW)
        ) u_slice (
            .rows (rows),
            .gsum (gs[g])
        );
    end

    always_comb begin
        vec_even = '0;
        vec_odd  = '0;
        for (int g = 0; g < GROUPS; g++) begin
            if (g % 2 == 0) vec_even = vec_even | (ACC_W'(gs[g]) << (g * SW));
            else            vec_odd  = vec_odd  | (ACC_W'(gs[g]) << (g * SW));
        end
    end

    // R2 checker: packed vectors must carry the full row sum
    logic [ACC_W-1:0] row_total;
    always_comb begin
        row_total = '0;
        for (int r = 0; r < PP_N; r++) row_total = row_total + rows[r];
        if (!$isunknown(rows)) begin
            a_r2_slice_pack: assert (ACC_W'(vec_even + vec_odd) == row_total)
                else $error("R2 slice vectors do not sum to rows");
        end
    end
endmodule

// File: rtl/gpp_csa32.sv
module gpp_csa32 #(
    parameter int W = gpp_mac_pkg::TOTAL_W
) (
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    input  logic [W-1:0] in_c,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] car_o
);
    logic [W-1:0] maj;
    assign sum_o = in_a ^ in_b ^ in_c;
    assign maj   = (in_a & in_b) | (in_a & in_c) | (in_b & in_c);
    assign car_o = {maj[W-2:0], 1'b0};
endmodule

// File: rtl/gpp_mac.sv
module gpp_mac
    import gpp_mac_pkg::*;
#(
    parameter int OP_W   = OPERAND_W,
    parameter int ACC_W  = TOTAL_W,
    parameter int GROUPS = SLICES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             clr,
    input  logic             cvt_req,
    input  logic [OP_W-1:0]  mcand,
    input  logic [OP_W-1:0]  mplier,
    output logic [ACC_W-1:0] red_s0,
    output logic [ACC_W-1:0] red_s1,
    output logic [ACC_W-1:0] red_s2,
    output logic [ACC_W-1:0] bin_out,
    output logic             bin_valid
);
    localparam int PP_N = OP_W / 2;

    logic [PP_N-1:0][ACC_W-1:0] rows;
    logic [ACC_W-1:0] vec_even, vec_odd;
    logic [ACC_W-1:0] l1_sum, l1_car, l2_sum, l2_car;
    acc_state_e st_q, st_d;

    gpp_booth_rows #(.OP_W(OP_W), .ACC_W(ACC_W)) u_booth (
        .x_in (mcand),
        .y_in (mplier),
        .rows (rows)
    );

    gpp_group_mult #(.ACC_W(ACC_W), .PP_N(PP_N), .GROUPS(GROUPS)) u_mult (
        .rows     (rows),
        .vec_even (vec_even),
        .vec_odd  (vec_odd)
    );

    // feedback counter array: state compressed, then merged with one product vector
    gpp_csa32 #(.W(ACC_W)) u_fold_state (
        .in_a (red_s0), .in_b (red_s1), .in_c (red_s2),
        .sum_o(l1_sum), .car_o(l1_car)
    );
    gpp_csa32 #(.W(ACC_W)) u_fold_prod (
        .in_a (l1_sum), .in_b (l1_car), .in_c (vec_even),
        .sum_o(l2_sum), .car_o(l2_car)
    );

    // controller next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_EMPTY:  if (!clr && in_valid) st_d = ST_LOADED;
            ST_LOADED: if (clr)              st_d = ST_EMPTY;
            default:                         st_d = ST_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_EMPTY;
        else        st_q <= st_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            red_s0    <= '0;
            red_s1    <= '0;
            red_s2    <= '0;
            bin_out   <= '0;
            bin_valid <= 1'b0;
        end else begin
            if (clr) begin
                red_s0 <= '0;
                red_s1 <= '0;
                red_s2 <= '0;
            end else if (in_valid) begin
                unique case (st_q)
                    ST_EMPTY: begin
                        red_s0 <= vec_even;
                        red_s1 <= vec_odd;
                        red_s2 <= '0;
                    end
                    default: begin
                        red_s0 <= l2_sum;
                        red_s1 <= l2_car;
                        red_s2 <= vec_odd;
                    end
                endcase
            end
            if (cvt_req) bin_out <= red_s0 + red_s1 + red_s2;
            bin_valid <= cvt_req;
        end
    end

    // checks on the redundant state
    logic [ACC_W-1:0] chk_total;
    logic [ACC_W-1:0] chk_prod;
    assign chk_total = red_s0 + red_s1 + red_s2;
    assign chk_prod  = $signed({{(ACC_W-OP_W){mcand[OP_W-1]}}, mcand})
                     * $signed({{(ACC_W-OP_W){mplier[OP_W-1]}}, mplier});

    a_r3_accum_total: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !clr) |=> chk_total == $past(chk_total + chk_prod));
    a_r4_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (red_s0 == '0 && red_s1 == '0 && red_s2 == '0));
    a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !in_valid) |=> ($stable(red_s0) && $stable(red_s1) && $stable(red_s2)));
    a_r6_cvt_value: assert property (@(posedge clk) disable iff (!rst_n)
        cvt_req |=> (bin_valid && bin_out == $past(chk_total)));
    a_r7_no_cvt: assert property (@(posedge clk) disable iff (!rst_n)
        !cvt_req |=> (!bin_valid && $stable(bin_out)));
    a_r10_first_load: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_EMPTY && in_valid && !clr) |=> red_s2 == '0);
endmodule

// File: tb/gpp_mac_bench.sv
module gpp_mac_bench;
    localparam int NV = 8;
    localparam logic [15:0] VA [NV] = '{16'd3, 16'hFFFF, 16'h8000, 16'h8000,
                                        16'h7FFF, 16'hFF85, 16'h0000, 16'hFFFF};
    localparam logic [15:0] VB [NV] = '{16'd5, 16'h0001, 16'h8000, 16'h7FFF,
                                        16'h7FFF, 16'h01C8, 16'h1234, 16'hFFFF};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, clr = 1'b0, cvt_req = 1'b0;
    logic [15:0] mcand = '0, mplier = '0;
    logic [39:0] red_s0, red_s1, red_s2, bin_out;
    logic bin_valid;
    int checks = 0, failures = 0;

    always #10 clk = ~clk;

    gpp_mac u_gpp_mac (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .clr(clr), .cvt_req(cvt_req),
        .mcand(mcand), .mplier(mplier), .red_s0(red_s0), .red_s1(red_s1),
        .red_s2(red_s2), .bin_out(bin_out), .bin_valid(bin_valid)
    );

    function automatic logic [39:0] prod(input logic [15:0] a, input logic [15:0] b);
        return $signed({{24{a[15]}}, a}) * $signed({{24{b[15]}}, b});
    endfunction

    task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic acc(input logic [15:0] a, input logic [15:0] b);
        @(negedge clk);
        in_valid = 1'b1; mcand = a; mplier = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic convert();
        @(negedge clk);
        cvt_req = 1'b1;
        @(negedge clk);
        cvt_req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [39:0] ref_sum;
        logic [39:0] snap0, snap1, snap2, snapb;
        repeat (3) @(negedge clk);
        // R8 reset state
        chk("R8 s0", red_s0, '0);
        chk("R8 s1", red_s1, '0);
        chk("R8 s2", red_s2, '0);
        chk("R8 bin", bin_out, '0);
        chk("R8 valid", 40'(bin_valid), '0);
        rst_n = 1'b1;

        // R1/R2 single products, R10 first load leaves s2 zero
        for (int i = 0; i < NV; i++) begin
            do_clear();
            acc(VA[i], VB[i]);
            chk("R10 first load s2", red_s2, '0);
            chk("R2 two vectors", red_s0 + red_s1, prod(VA[i], VB[i]));
            convert();
            chk("R1 product", bin_out, prod(VA[i], VB[i]));
        end

        // R3 running sum over the table, back to back
        do_clear();
        ref_sum = '0;
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            in_valid = 1'b1; mcand = VA[i]; mplier = VB[i];
            ref_sum = ref_sum + prod(VA[i], VB[i]);
            @(negedge clk);
        end
        in_valid = 1'b0;
        chk("R3 total", red_s0 + red_s1 + red_s2, ref_sum);
        convert();
        chk("R6 value", bin_out, ref_sum);
        chk("R6 pulse", 40'(bin_valid), 40'd1);

        // R7 bin holds, valid low, after further accumulates
        acc(16'd100, 16'd7);
        ref_sum = ref_sum + 40'd700;
        chk("R7 valid low", 40'(bin_valid), '0);
        chk("R7 bin holds", bin_out, ref_sum - 40'd700);

        // R5 idle with changing operands
        snap0 = red_s0; snap1 = red_s1; snap2 = red_s2;
        @(negedge clk); mcand = 16'h1357; mplier = 16'h8001;
        @(negedge clk); mcand = 16'hBEEF; mplier = 16'h7777;
        @(negedge clk);
        chk("R5 s0", red_s0, snap0);
        chk("R5 s1", red_s1, snap1);
        chk("R5 s2", red_s2, snap2);

        // R6 convert together with an accumulate uses the old total
        snapb = ref_sum;
        @(negedge clk);
        cvt_req = 1'b1; in_valid = 1'b1; mcand = 16'd2; mplier = 16'd3;
        @(negedge clk);
        cvt_req = 1'b0; in_valid = 1'b0;
        ref_sum = ref_sum + 40'd6;
        chk("R6 pre-update", bin_out, snapb);
        chk("R3 after collide", red_s0 + red_s1 + red_s2, ref_sum);

        // R4 clear wins over valid
        @(negedge clk);
        clr = 1'b1; in_valid = 1'b1; mcand = 16'h7FFF; mplier = 16'h7FFF;
        @(negedge clk);
        clr = 1'b0; in_valid = 1'b0;
        chk("R4 s0", red_s0, '0);
        chk("R4 s1", red_s1, '0);
        chk("R4 s2", red_s2, '0);

        // R9 wrap: 512 then 1024 products of 2^30
        @(negedge clk);
        in_valid = 1'b1; mcand = 16'h8000; mplier = 16'h8000;
        repeat (512) @(negedge clk);
        in_valid = 1'b0;
        convert();
        chk("R9 half wrap", bin_out, 40'h80_0000_0000);
        @(negedge clk);
        in_valid = 1'b1;
        repeat (512) @(negedge clk);
        in_valid = 1'b0;
        convert();
        chk("R9 full wrap", bin_out, '0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule